// File: doc/BRIEF.md
# Dual-Clock Serial Field Store

This block is a sequential-access picture store. It has two serial ports, one that writes and one that reads, and each port runs on its own clock. Neither port is given an address. Each port keeps a running word counter. A port reset puts that counter back to location zero. The gap between the words going in and the words coming out therefore depends only on when the two resets are applied. In video use this turns the store into a delay line one field long, or into a line or field buffer.

Each port has two kinds of gating:

- **Counter gating.** A port enable stops the counter, so the port simply pauses.
- **Data masking.** A mask input leaves the counter running. On the write side it protects the addressed location, which allows selective overwrite such as an inset picture. On the read side it forces the output word to zero, which skips that word.

Storage is a dual-clock array that block RAM can be inferred from. Its depth is a parameter and each word is 8 bits.

Top module: `serial_field_store`

## Requirements
- R1: Words written through the write port, on the write clock, are read back in the same order through the read port, on a read clock of a different rate. Stored words persist however long either clock sits idle between accesses.
- R2: When `wr_rst` is high on a `wr_clk` rising edge, that edge accesses location 0 if `wr_en` is high. The next enabled edge accesses location 1.
- R3: When `rd_rst` is high on a `rd_clk` rising edge with `rd_en` high, location 0 is read. Its word is on `rd_data` after that same edge. There are no extra latency cycles after a reset.
- R4: An edge with `wr_en` low writes nothing and does not advance the write counter.
- R5: An edge with `rd_en` low does not advance the read counter and leaves `rd_data` unchanged, whatever the value of `rd_oe`.
- R6: An edge with `wr_en` high and `wr_ie` low advances the write counter but leaves the addressed location unchanged.
- R7: An edge with `rd_en` high and `rd_oe` low advances the read counter and drives `rd_data` to 0x00 after that edge.
- R8: Both counters wrap from location DEPTH-1 back to 0 with no flag.
- R9: An edge with `rd_rst` high and `rd_en` low drives `rd_data` to 0x00 and points the read counter at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst | input | 1 | Synchronous write counter reset, active high |
| wr_en | input | 1 | Write enable; low pauses the write counter |
| wr_ie | input | 1 | Write data mask; low protects the addressed location |
| wr_data | input | 8 | Serial write word |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Synchronous read counter reset, active high |
| rd_en | input | 1 | Read enable; low pauses the read counter |
| rd_oe | input | 1 | Read output mask; low zeroes the output word |
| rd_data | output | 8 | Serial read word, registered on rd_clk |

## Verification
A write takes effect at the `wr_clk` rising edge where its inputs are sampled. The bench cannot see that edge directly. It observes every write later, through reads made in a separate phase after the write stream has finished.

Each read result is due on `rd_data` at the same `rd_clk` rising edge that samples the read controls. The bench drives the read controls on a falling edge and checks the word on the next falling edge, so one rising edge lies between stimulus and check.

The hold and mask cases are checked at the same point. The cases that depend on a paused counter are confirmed by the address of the next word that comes out.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sfs_addr_ctr.sv
// Serial word counter shared by both ports: synchronous clear, gated advance, wrap.
module sfs_addr_ctr #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] acc_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt;
  logic [AW-1:0] cnt_nxt;
  logic          started = 1'b0;

  // Address used by this edge: a clear takes effect on the very same edge.
  assign acc_addr = clr ? '0 : cnt;

  always_comb begin
    cnt_nxt = acc_addr;
    if (adv) cnt_nxt = (acc_addr == LAST) ? '0 : acc_addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    cnt <= cnt_nxt;
    if (clr) started <= 1'b1;
  end

  // R2 R3
  // clr_load_chk
  clr_load_chk: assert property (@(posedge clk) disable iff (!started)
    (clr && adv) |=> (cnt == AW'(1 % DEPTH)));

  // R4 R5
  // hold_chk
  hold_chk: assert property (@(posedge clk) disable iff (!started)
    (!clr && !adv) |=> $stable(cnt));

  // R8
  // wrap_chk
  wrap_chk: assert property (@(posedge clk) disable iff (!started)
    (!clr && adv && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/sfs_dpram.sv
// Simple dual-port, dual-clock array written in the block-RAM inference pattern.
module sfs_dpram
  import sfs_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/serial_field_store.sv
module serial_field_store
  import sfs_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic              wr_ie,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic              rd_oe,
  output logic [WORD_W-1:0] rd_data
);
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  word_t         ram_q;
  logic          show_q;
  logic          rd_started = 1'b0;

  // Write side: the counter advances on enable; the mask only blocks the store.
  sfs_addr_ctr #(.DEPTH(DEPTH)) u_wctr (
    .clk(wr_clk), .clr(wr_rst), .adv(wr_en), .acc_addr(waddr)
  );

  // Read side: the counter advances on enable regardless of the output mask.
  sfs_addr_ctr #(.DEPTH(DEPTH)) u_rctr (
    .clk(rd_clk), .clr(rd_rst), .adv(rd_en), .acc_addr(raddr)
  );

  sfs_dpram #(.DEPTH(DEPTH)) u_ram (
    .wclk(wr_clk), .we(wr_en & wr_ie), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_en), .raddr(raddr), .rdata(ram_q)
  );

  // Output mask is registered alongside the RAM output register.
  always_ff @(posedge rd_clk) begin
    if (rd_en)       show_q <= rd_oe;
    else if (rd_rst) show_q <= 1'b0;
    if (rd_rst) rd_started <= 1'b1;
  end

  assign rd_data = show_q ? ram_q : '0;

  // R7
  // oe_mask_chk
  oe_mask_chk: assert property (@(posedge rd_clk) disable iff (!rd_started)
    (rd_en && !rd_oe) |=> (rd_data == '0));

  // R9
  // rd_clear_chk
  rd_clear_chk: assert property (@(posedge rd_clk) disable iff (!rd_started)
    (rd_rst && !rd_en) |=> (rd_data == '0));

  // R5
  // rd_hold_chk
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_started)
    (!rd_en && !rd_rst) |=> $stable(rd_data));
endmodule

// File: tb/serial_field_store_tb.sv
module serial_field_store_tb;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic       rst;
    logic       en;
    logic       oe;
    logic [7:0] exp;
    int         req;
  } rvec_t;

  // Read table; the store is loaded first as:
  // 0:55 1:A1 2:33 3..15:A3..AF
  localparam rvec_t VECS [23] = '{
    '{1'b1, 1'b0, 1'b1, 8'h00, 9},  // R9 clear
    '{1'b1, 1'b1, 1'b1, 8'h55, 3},  // R3 loc 0, no added latency
    '{1'b0, 1'b1, 1'b1, 8'hA1, 6},  // R6 masked write left A1
    '{1'b0, 1'b1, 1'b1, 8'h33, 4},  // R4 paused write landed at 2
    '{1'b0, 1'b0, 1'b1, 8'h33, 5},  // R5 hold
    '{1'b0, 1'b0, 1'b0, 8'h33, 5},  // R5 hold, mask ignored
    '{1'b0, 1'b1, 1'b1, 8'hA3, 5},  // R5 counter did not move
    '{1'b0, 1'b1, 1'b0, 8'h00, 7},  // R7 loc 4 skipped
    '{1'b0, 1'b1, 1'b1, 8'hA5, 7},  // R7 counter moved past 4
    '{1'b0, 1'b1, 1'b1, 8'hA6, 1},  // R1 stream
    '{1'b0, 1'b1, 1'b1, 8'hA7, 1},
    '{1'b0, 1'b1, 1'b1, 8'hA8, 1},
    '{1'b0, 1'b1, 1'b1, 8'hA9, 1},
    '{1'b0, 1'b1, 1'b1, 8'hAA, 1},
    '{1'b0, 1'b1, 1'b1, 8'hAB, 1},
    '{1'b0, 1'b1, 1'b1, 8'hAC, 1},
    '{1'b0, 1'b1, 1'b1, 8'hAD, 1},
    '{1'b0, 1'b1, 1'b1, 8'hAE, 1},
    '{1'b0, 1'b1, 1'b1, 8'hAF, 1},
    '{1'b0, 1'b1, 1'b1, 8'h55, 8},  // R8 read wrap
    '{1'b1, 1'b1, 1'b1, 8'h55, 3},  // R3 restart
    '{1'b0, 1'b1, 1'b1, 8'hA1, 3},
    '{1'b0, 1'b1, 1'b0, 8'h00, 7}   // R7
  };

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst = 1'b0, wr_en = 1'b0, wr_ie = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_rst = 1'b0, rd_en = 1'b0, rd_oe = 1'b0;
  logic [7:0] rd_data;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz
  always #3.5 rd_clk = ~rd_clk;   // unrelated read rate

  serial_field_store #(.DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_ie(wr_ie),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_oe(rd_oe), .rd_data(rd_data)
  );

  task automatic wstep(input logic r, input logic e, input logic m,
                       input logic [7:0] d);
    @(negedge wr_clk);
    wr_rst = r; wr_en = e; wr_ie = m; wr_data = d;
  endtask

  // Drive on a falling edge; result is due after the next rising edge.
  task automatic rstep(input logic r, input logic e, input logic m,
                       input logic [7:0] exp, input int req);
    rd_rst = r; rd_en = e; rd_oe = m;
    @(negedge rd_clk);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL R%0d: rd_data=%02h expected %02h", req, rd_data, exp);
    end
  endtask

  initial begin
    // Load: R2 reset to 0, then a full pass and R8 wrap of the write counter.
    wstep(1'b1, 1'b1, 1'b1, 8'hA0);
    for (int i = 1; i < DEPTH; i++) wstep(1'b0, 1'b1, 1'b1, 8'(8'hA0 + i));
    wstep(1'b0, 1'b1, 1'b1, 8'h55);          // R8 wraps onto loc 0
    wstep(1'b0, 1'b0, 1'b1, 8'hEE);          // R4 paused
    wstep(1'b0, 1'b0, 1'b1, 8'hEE);
    wstep(1'b0, 1'b1, 1'b0, 8'h77);          // R6 masked at loc 1
    wstep(1'b0, 1'b1, 1'b1, 8'h33);          // loc 2
    wstep(1'b0, 1'b0, 1'b0, 8'h00);
    repeat (20) @(negedge wr_clk);           // write clock idles, R1 retention

    @(negedge rd_clk);
    foreach (VECS[k]) rstep(VECS[k].rst, VECS[k].en, VECS[k].oe,
                            VECS[k].exp, VECS[k].req);

    // Directed: R2 write reset in mid-stream restarts at location 0.
    rd_en = 1'b0; rd_rst = 1'b0;
    wstep(1'b1, 1'b1, 1'b1, 8'h99);
    wstep(1'b0, 1'b1, 1'b1, 8'h98);
    wstep(1'b0, 1'b0, 1'b0, 8'h00);
    repeat (4) @(negedge wr_clk);
    @(negedge rd_clk);
    rstep(1'b1, 1'b1, 1'b1, 8'h99, 2);       // R2 loc 0
    rstep(1'b0, 1'b1, 1'b1, 8'h98, 2);       // R2 loc 1
    rstep(1'b0, 1'b1, 1'b1, 8'h33, 1);       // R1 loc 2 untouched
    rstep(1'b1, 1'b0, 1'b0, 8'h00, 9);       // R9 clear
    rstep(1'b0, 1'b1, 1'b1, 8'h99, 9);       // R9 pointer at 0
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run stalled, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule